// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two bidirectional data ports, A and B, through a non-inverting path of parameterised width (eight bits by default). Each transfer direction has its own storage register, and each register has its own capture clock. A per-direction source select chooses what is driven out: either the live value from the opposite port or the contents of that direction's register. A shared active-low output enable and a direction control decide which port, if any, the block drives.

Each port is split into an input vector, an output vector and an output-enable bit, so a tri-state pad can be placed around it at the chip level. The registers load on every rising edge of their clocks, whatever the enable and direction are. This means data can be captured while both ports are isolated and replayed later. When a port is being driven, its register captures the value the block itself places on that port.

Top module: `regbus_xcvr`

## Requirements
- R1: The A-to-B register loads the port A value on every rising edge of `clk_ab`, whatever the values of `oe_n` and `dir_to_b`.
- R2: The B-to-A register loads the port B value on every rising edge of `clk_ba`, whatever the values of `oe_n` and `dir_to_b`.
- R3: While `oe_n` is 1, both `a_oe` and `b_oe` are 0 and the registers still load. When neither clock rises, both registers keep their contents even if the port inputs change.
- R4: While `oe_n` is 0, `dir_to_b` = 0 gives `a_oe` = 1 and `b_oe` = 0, and `dir_to_b` = 1 gives `b_oe` = 1 and `a_oe` = 0.
- R5: While port A is driven, `sel_ba` = 0 puts `b_in` on `a_out`, and `sel_ba` = 1 puts the B-to-A register on `a_out`.
- R6: While port B is driven, `sel_ab` = 0 puts `a_in` on `b_out`, and `sel_ab` = 1 puts the A-to-B register on `b_out`.
- R7: `a_oe` and `b_oe` are never 1 together. An output whose enable is 0 reads all zeros. The path does not invert data.
- R8: When `clk_ab` and `clk_ba` rise on the same edge while the outputs are disabled, both registers load their own port values in that cycle.
- R9: A register clocked while its source port is driven by the block loads the value on that port's output (`a_out` for the A-to-B register, `b_out` for the B-to-A register).
- R10: While `rst_n` is 0, both registers are cleared to zero and both `a_oe` and `b_oe` are 0, with no clock needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| oe_n | input | 1 | Output enable, active low |
| dir_to_b | input | 1 | 0: drive port A, 1: drive port B |
| sel_ab | input | 1 | Source for port B: 0 live A, 1 A-to-B register |
| sel_ba | input | 1 | Source for port A: 0 live B, 1 B-to-A register |
| a_in | input | DATA_W | Value seen on port A |
| a_out | output | DATA_W | Value driven on port A |
| a_oe | output | 1 | Port A driver enable |
| b_in | input | DATA_W | Value seen on port B |
| b_out | output | DATA_W | Value driven on port B |
| b_oe | output | 1 | Port B driver enable |

## Verification
The hardest case to reach is a register capturing while its own port is being driven by the block (R9). In that case the stored value comes from the opposite port or the opposite register, not from the pin input. The stimulus reaches it by enabling the outputs toward one port and pulsing that port's clock, then turning the direction round in stored mode and reading the register back. Random cycles also mix the clocks with all enable, direction and select settings, so captures during drive, during isolation and on both edges together (R8) all occur many times.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   localparam int N_CH  = 2;
   localparam int CH_AB = 0;
   localparam int CH_BA = 1;

   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_e;
endpackage

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl (
   input  logic rst_n,
   input  logic oe_n,
   input  logic dir_to_b,
   output logic drv_a,
   output logic drv_b
);
   logic active;

   assign active = rst_n & ~oe_n;
   assign drv_a  = active & ~dir_to_b;
   assign drv_b  = active &  dir_to_b;

   // R7: the two port drivers are never enabled together
   always_comb begin
      a_r7_one_driver: assert (!(drv_a && drv_b));
   end

   // R3: a high output enable isolates both ports
   always_comb begin
      if (oe_n) a_r3_isolated: assert (!drv_a && !drv_b);
   end

   // R10: reset keeps both ports quiet
   always_comb begin
      if (!rst_n) a_r10_quiet: assert (!drv_a && !drv_b);
   end
endmodule

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   localparam logic [DATA_W-1:0] CLR = '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= CLR;
      else        q <= d;
   end

   // R10: contents are cleared while reset is held
   always_comb begin
      if (!rst_n) a_r10_cleared: assert (q == CLR);
   end
endmodule

// File: rtl/xcvr_path_sel.sv
module xcvr_path_sel
   import xcvr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              en,
   input  src_e              src,
   input  logic [DATA_W-1:0] live,
   input  logic [DATA_W-1:0] stored,
   output logic [DATA_W-1:0] out
);
   logic [DATA_W-1:0] pick;

   always_comb begin
      unique case (src)
         SRC_LIVE:   pick = live;
         SRC_STORED: pick = stored;
         default:    pick = live;
      endcase
   end

   assign out = en ? pick : '0;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
   import xcvr_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              rst_n,
   input  logic              clk_ab,
   input  logic              clk_ba,
   input  logic              oe_n,
   input  logic              dir_to_b,
   input  logic              sel_ab,
   input  logic              sel_ba,
   input  logic [DATA_W-1:0] a_in,
   output logic [DATA_W-1:0] a_out,
   output logic              a_oe,
   input  logic [DATA_W-1:0] b_in,
   output logic [DATA_W-1:0] b_out,
   output logic              b_oe
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("regbus_xcvr: DATA_W must be at least 1");
      end
   endgenerate

   logic drv_a, drv_b;

   xcvr_drive_ctrl u_ctrl (
      .rst_n    (rst_n),
      .oe_n     (oe_n),
      .dir_to_b (dir_to_b),
      .drv_a    (drv_a),
      .drv_b    (drv_b)
   );

   // channel CH_AB: captures port A, drives port B
   // channel CH_BA: captures port B, drives port A
   logic [N_CH-1:0]             ch_clk, ch_sel, ch_en;
   logic [N_CH-1:0][DATA_W-1:0] ch_live, ch_cap, ch_q, ch_out;
   logic [DATA_W-1:0]           a_port, b_port;

   assign ch_clk[CH_AB]  = clk_ab;
   assign ch_clk[CH_BA]  = clk_ba;
   assign ch_sel[CH_AB]  = sel_ab;
   assign ch_sel[CH_BA]  = sel_ba;
   assign ch_en[CH_AB]   = drv_b;
   assign ch_en[CH_BA]   = drv_a;
   assign ch_live[CH_AB] = a_in;
   assign ch_live[CH_BA] = b_in;

   assign a_out = ch_out[CH_BA];
   assign b_out = ch_out[CH_AB];
   assign a_oe  = drv_a;
   assign b_oe  = drv_b;

   // value present on each pin, including what the block drives there
   assign a_port = drv_a ? a_out : a_in;
   assign b_port = drv_b ? b_out : b_in;
   assign ch_cap[CH_AB] = a_port;
   assign ch_cap[CH_BA] = b_port;

   generate
      for (genvar g = 0; g < N_CH; g++) begin : g_ch
         xcvr_store_reg #(.DATA_W(DATA_W)) u_reg (
            .clk   (ch_clk[g]),
            .rst_n (rst_n),
            .d     (ch_cap[g]),
            .q     (ch_q[g])
         );

         xcvr_path_sel #(.DATA_W(DATA_W)) u_sel (
            .en     (ch_en[g]),
            .src    (src_e'(ch_sel[g])),
            .live   (ch_live[g]),
            .stored (ch_q[g]),
            .out    (ch_out[g])
         );
      end
   endgenerate

   // R1: an undriven port A is captured from its pin input
   a_r1_capture_pin: assert property (@(posedge clk_ab) disable iff (!rst_n)
      !a_oe |=> ch_q[CH_AB] == $past(a_in));

   // R2: an undriven port B is captured from its pin input
   a_r2_capture_pin: assert property (@(posedge clk_ba) disable iff (!rst_n)
      !b_oe |=> ch_q[CH_BA] == $past(b_in));

   // R9: a driven port A is captured from the block's own output
   a_r9_capture_a_drive: assert property (@(posedge clk_ab) disable iff (!rst_n)
      a_oe |=> ch_q[CH_AB] == $past(a_out));

   // R9: a driven port B is captured from the block's own output
   a_r9_capture_b_drive: assert property (@(posedge clk_ba) disable iff (!rst_n)
      b_oe |=> ch_q[CH_BA] == $past(b_out));

   // R7: an undriven output reads zero
   always_comb begin
      if (!a_oe) a_r7_a_zero: assert (a_out == '0);
      if (!b_oe) a_r7_b_zero: assert (b_out == '0);
   end
endmodule

// File: tb/test_regbus_xcvr.sv
module test_regbus_xcvr;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n, clk_ab, clk_ba, oe_n, dir_to_b, sel_ab, sel_ba;
   logic [W-1:0] a_in, b_in, a_out, b_out;
   logic         a_oe, b_oe;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_ab, m_ba;

   always #10 clk = ~clk;

   regbus_xcvr #(.DATA_W(W)) i_regbus_xcvr (
      .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n),
      .dir_to_b(dir_to_b), .sel_ab(sel_ab), .sel_ba(sel_ba),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   function automatic logic f_drv_a(logic oen, logic d);
      return !oen && !d;
   endfunction
   function automatic logic f_drv_b(logic oen, logic d);
      return !oen && d;
   endfunction

   task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle: apply at negedge, check outputs, pulse clocks at posedge
   task automatic step(logic oen, logic d, logic sab, logic sba,
                       logic pab, logic pba, logic [W-1:0] av, logic [W-1:0] bv);
      logic da, db;
      logic [W-1:0] ea, eb, pa, pb;
      @(negedge clk);
      oe_n = oen; dir_to_b = d; sel_ab = sab; sel_ba = sba;
      da = f_drv_a(oen, d);
      db = f_drv_b(oen, d);
      if (!da) a_in = av;
      if (!db) b_in = bv;
      ea = da ? (sba ? m_ba : b_in) : '0;
      eb = db ? (sab ? m_ab : a_in) : '0;
      #4;
      chk(a_oe == da, oen ? "R3 a_oe" : "R4 a_oe", W'(a_oe), W'(da));
      chk(b_oe == db, oen ? "R3 b_oe" : "R4 b_oe", W'(b_oe), W'(db));
      chk(a_out == ea, da ? (sba ? "R5 stored" : "R5 live") : "R7 a idle", a_out, ea);
      chk(b_out == eb, db ? (sab ? "R6 stored" : "R6 live") : "R7 b idle", b_out, eb);
      pa = da ? ea : a_in;
      pb = db ? eb : b_in;
      @(posedge clk);
      clk_ab = pab; clk_ba = pba;
      if (pab) m_ab = pa;
      if (pba) m_ba = pb;
      #4;
      clk_ab = 1'b0; clk_ba = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      rst_n = 1'b0; clk_ab = 1'b0; clk_ba = 1'b0; oe_n = 1'b0; dir_to_b = 1'b0;
      sel_ab = 1'b1; sel_ba = 1'b1; a_in = 8'h5A; b_in = 8'hA5;
      m_ab = '0; m_ba = '0;
      repeat (3) @(posedge clk);
      #2;
      // R10: enables low during reset although oe_n is low
      chk(a_oe == 1'b0, "R10 a_oe", W'(a_oe), '0);
      chk(b_oe == 1'b0, "R10 b_oe", W'(b_oe), '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: registers read back zero
      step(0, 1, 1, 0, 0, 0, 8'h11, 8'h22);
      step(0, 0, 0, 1, 0, 0, 8'h33, 8'h44);

      // R8: isolated, both clocks together
      step(1, 0, 0, 0, 1, 1, 8'hC3, 8'h3C);
      step(0, 1, 1, 0, 0, 0, 8'h00, 8'h00);   // R6 stored C3
      step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00);   // R5 stored 3C

      // R3: hold with no clocks while inputs change
      step(1, 1, 1, 1, 0, 0, 8'hFF, 8'hEE);
      step(1, 0, 1, 1, 0, 0, 8'h01, 8'h02);
      step(0, 1, 1, 0, 0, 0, 8'h77, 8'h00);
      step(0, 0, 0, 1, 0, 0, 8'h00, 8'h66);

      // R1/R2: capture while outputs point elsewhere
      step(0, 1, 0, 0, 1, 0, 8'h9D, 8'h00);   // B driven, A-to-B loads a_in
      step(0, 0, 0, 0, 0, 1, 8'h00, 8'h4E);   // A driven, B-to-A loads b_in
      step(0, 1, 1, 0, 0, 0, 8'h00, 8'h00);
      step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00);

      // R9: port A driven with live B, A-to-B register captures the drive
      step(0, 0, 0, 0, 1, 0, 8'h00, 8'hB7);
      step(0, 1, 1, 0, 0, 0, 8'h00, 8'h00);   // b_out must read B7
      // R9: port B driven from its register, B-to-A captures it
      step(0, 1, 1, 0, 0, 1, 8'h12, 8'h00);
      step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00);   // a_out must read B7

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [5:0] c;
         c = 6'($urandom);
         step(c[0] & c[5], c[1], c[2], c[3], c[4], c[5] ^ c[0],
              W'($urandom), W'($urandom));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule